// File: doc/BRIEF.md
# Legacy Interrupt Routing Mode Register

This block holds the single setting that decides whether the two legacy interrupt lines reach the boot processor. The two lines are the maskable request from the 8259-style controller and the non-maskable interrupt. In the default state both lines drive the processor's interrupt and NMI pins directly. When software selects the other route, the lines feed the local interrupt controller's two local inputs instead.

Software reaches the setting indirectly, through two byte-wide ports in I/O space. It first writes a selector byte to the index port, which sits at I/O address 22h. It then writes the setting to the data port at 23h. Only the selector value 70h connects the data port to the mode bit. The index stays in place after a data write, so software can write the data port again and again without selecting again. A parameter decides whether the two ports can also be read back. Reset and the system-wide INIT both return the block to the direct route.

Top module: `irq_mode_ctl`

## Requirements
- R1: After synchronous reset (`rst` high at a clock edge) the index register and the mode bit are zero, and the routing is direct.
- R2: A cycle with `init` high clears the index register and the mode bit at that clock edge. This also happens when a port write arrives in the same cycle, because INIT takes priority over the write.
- R3: A write to the index port (full 16-bit address 0x0022) stores all 8 data bits into the index register. When reads are enabled, reading that port returns the stored index.
- R4: A write to the data port (address 0x0023) while the index holds 0x70 stores data bit 0 as the mode bit. The mode bit decodes as 0 = direct route and 1 = local-controller route. The new route takes effect from the clock edge that accepts the write.
- R5: A write to the data port while the index holds any value other than 0x70 leaves the mode bit unchanged.
- R6: Data bits 7..1 are discarded. A read of the data port returns {7'b0, mode} while the index holds 0x70, and returns 0x00 for any other index.
- R7: The index register keeps its value across data-port writes and across all port reads.
- R8: With mode 0, `cpu_intr_o` follows `pic_intr_i` and `cpu_nmi_o` follows `nmi_i`, both combinationally, and `lint0_o` and `lint1_o` are held at 0.
- R9: With mode 1, `lint0_o` follows `pic_intr_i` and `lint1_o` follows `nmi_i`, both combinationally, and `cpu_intr_o` and `cpu_nmi_o` are held at 0.
- R10: With parameter READABLE = 0, `io_rdata_o` is always 0x00, while writes and routing behave exactly as with READABLE = 1.
- R11: Read data is registered. `io_rdata_o` shows the value for a read one clock after the cycle with `io_rd_i` high. It is 0x00 in every other cycle, and also 0x00 after a read of any address other than the two ports.
- R12: Reads and writes to any address other than 0x0022 and 0x0023 change neither the index nor the mode bit. The full 16-bit address is compared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init | input | 1 | System-wide INIT request, synchronous, active high |
| io_wr_i | input | 1 | I/O write strobe, one cycle per write |
| io_rd_i | input | 1 | I/O read strobe, one cycle per read |
| io_addr_i | input | 16 | I/O port address |
| io_wdata_i | input | 8 | I/O write data |
| io_rdata_o | output | 8 | Registered I/O read data |
| pic_intr_i | input | 1 | Legacy interrupt controller request line |
| nmi_i | input | 1 | Non-maskable interrupt source |
| cpu_intr_o | output | 1 | Direct processor interrupt pin |
| cpu_nmi_o | output | 1 | Direct processor NMI pin |
| lint0_o | output | 1 | Local interrupt controller input 0 (carries the maskable request) |
| lint1_o | output | 1 | Local interrupt controller input 1 (carries the NMI) |

## Verification
The bench sweeps all 256 index values against a data write. A decoder that matched only part of the selector, or that updated on a stale index, would change the mode for some index other than 0x70. It also sweeps all 256 data bytes, which catches a design that stores the wrong bit or leaks upper bits into the read-back. Every combination of the two inputs is driven in both modes, so a crossed or leaking mux shows up on a pin that should be quiet. Further cases target INIT arriving together with a write, aliased addresses such as 0x0122, and a write-only instance. A design that let the write win over INIT, decoded only the low byte of the address, or leaked stored data on reads would fail on these.

// File: rtl/irqm_pkg.sv
package irqm_pkg;

  typedef enum logic {
    ROUTE_DIRECT = 1'b0,
    ROUTE_LAPIC  = 1'b1
  } route_e;

  function automatic logic addr_match(input logic [15:0] a, input logic [15:0] port);
    return a == port;
  endfunction

endpackage

// File: rtl/irqm_port_decode.sv
module irqm_port_decode #(
  parameter int          ADDR_W     = 16,
  parameter logic [15:0] INDEX_PORT = 16'h0022,
  parameter logic [15:0] DATA_PORT  = 16'h0023
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  output logic              wr_index,
  output logic              wr_data,
  output logic              rd_index,
  output logic              rd_data
);
  localparam logic [ADDR_W-1:0] IDX_A = INDEX_PORT[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] DAT_A = DATA_PORT[ADDR_W-1:0];

  logic hit_idx, hit_dat;

  always_comb begin
    hit_idx  = (addr == IDX_A);
    hit_dat  = (addr == DAT_A);
    wr_index = wr_en & hit_idx;
    wr_data  = wr_en & hit_dat;
    rd_index = rd_en & hit_idx;
    rd_data  = rd_en & hit_dat;
  end

  // R12: a single access never selects both ports
  a_r12_one_port: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wr_index, wr_data}) && $onehot0({rd_index, rd_data}));

endmodule

// File: rtl/irqm_mode_regs.sv
module irqm_mode_regs
  import irqm_pkg::*;
#(
  parameter int          DATA_W   = 8,
  parameter logic [7:0]  MODE_SEL = 8'h70,
  parameter bit          READABLE = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              init,
  input  logic              wr_index,
  input  logic              wr_data,
  input  logic              rd_index,
  input  logic              rd_data,
  input  logic [DATA_W-1:0] wdata,
  output route_e            mode,
  output logic [DATA_W-1:0] rdata
);
  localparam logic [DATA_W-1:0] SEL = DATA_W'(MODE_SEL);

  logic [DATA_W-1:0] index_q;
  route_e            mode_q;
  logic              selected;

  assign selected = (index_q == SEL);
  assign mode     = mode_q;

  always_ff @(posedge clk) begin
    if (rst || init) begin
      index_q <= '0;
      mode_q  <= ROUTE_DIRECT;
    end else begin
      if (wr_index)
        index_q <= wdata;
      if (wr_data && selected)
        mode_q <= route_e'(wdata[0]);
    end
  end

  generate
    if (READABLE) begin : g_rd
      always_ff @(posedge clk) begin
        if (rst)
          rdata <= '0;
        else if (rd_index)
          rdata <= index_q;
        else if (rd_data && selected)
          rdata <= {{(DATA_W-1){1'b0}}, mode_q};
        else
          rdata <= '0;
      end
    end else begin : g_wo
      assign rdata = '0;
    end
  endgenerate

  // R2: INIT clears both registers
  a_r2_init_clears: assert property (@(posedge clk) disable iff (rst)
    init |=> (index_q == '0) && (mode_q == ROUTE_DIRECT));

  // R4: selected data write stores bit 0
  a_r4_store_bit0: assert property (@(posedge clk) disable iff (rst)
    (!init && wr_data && selected) |=> (mode_q == route_e'($past(wdata[0]))));

  // R5: no selected write, no change
  a_r5_mode_hold: assert property (@(posedge clk) disable iff (rst)
    (!init && !(wr_data && selected)) |=> $stable(mode_q));

  // R7: index changes only on an index-port write
  a_r7_index_hold: assert property (@(posedge clk) disable iff (rst)
    (!init && !wr_index) |=> $stable(index_q));

  // R11: no read, no data on the bus
  a_r11_idle_zero: assert property (@(posedge clk) disable iff (rst)
    (!rd_index && !rd_data) |=> (rdata == '0));

endmodule

// File: rtl/irqm_route.sv
module irqm_route
  import irqm_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  route_e mode,
  input  logic   pic_intr,
  input  logic   nmi,
  output logic   cpu_intr,
  output logic   cpu_nmi,
  output logic   lint0,
  output logic   lint1
);
  always_comb begin
    cpu_intr = 1'b0;
    cpu_nmi  = 1'b0;
    lint0    = 1'b0;
    lint1    = 1'b0;
    case (mode)
      ROUTE_DIRECT: begin
        cpu_intr = pic_intr;
        cpu_nmi  = nmi;
      end
      ROUTE_LAPIC: begin
        lint0 = pic_intr;
        lint1 = nmi;
      end
      default: ;
    endcase
  end

  // R8: direct route
  a_r8_direct_path: assert property (@(posedge clk) disable iff (rst)
    (mode == ROUTE_DIRECT) |-> (cpu_intr == pic_intr) && (cpu_nmi == nmi) && !lint0 && !lint1);

  // R9: local-controller route
  a_r9_lapic_path: assert property (@(posedge clk) disable iff (rst)
    (mode == ROUTE_LAPIC) |-> (lint0 == pic_intr) && (lint1 == nmi) && !cpu_intr && !cpu_nmi);

endmodule

// File: rtl/irq_mode_ctl.sv
module irq_mode_ctl
  import irqm_pkg::*;
#(
  parameter int          ADDR_W     = 16,
  parameter int          DATA_W     = 8,
  parameter logic [15:0] INDEX_PORT = 16'h0022,
  parameter logic [15:0] DATA_PORT  = 16'h0023,
  parameter logic [7:0]  MODE_SEL   = 8'h70,
  parameter bit          READABLE   = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              init,
  input  logic              io_wr_i,
  input  logic              io_rd_i,
  input  logic [ADDR_W-1:0] io_addr_i,
  input  logic [DATA_W-1:0] io_wdata_i,
  output logic [DATA_W-1:0] io_rdata_o,
  input  logic              pic_intr_i,
  input  logic              nmi_i,
  output logic              cpu_intr_o,
  output logic              cpu_nmi_o,
  output logic              lint0_o,
  output logic              lint1_o
);
  logic   wr_index, wr_data, rd_index, rd_data;
  route_e mode;

  irqm_port_decode #(
    .ADDR_W(ADDR_W), .INDEX_PORT(INDEX_PORT), .DATA_PORT(DATA_PORT)
  ) u_dec (
    .clk(clk), .rst(rst),
    .wr_en(io_wr_i), .rd_en(io_rd_i), .addr(io_addr_i),
    .wr_index(wr_index), .wr_data(wr_data),
    .rd_index(rd_index), .rd_data(rd_data)
  );

  irqm_mode_regs #(
    .DATA_W(DATA_W), .MODE_SEL(MODE_SEL), .READABLE(READABLE)
  ) u_regs (
    .clk(clk), .rst(rst), .init(init),
    .wr_index(wr_index), .wr_data(wr_data),
    .rd_index(rd_index), .rd_data(rd_data),
    .wdata(io_wdata_i), .mode(mode), .rdata(io_rdata_o)
  );

  irqm_route u_route (
    .clk(clk), .rst(rst), .mode(mode),
    .pic_intr(pic_intr_i), .nmi(nmi_i),
    .cpu_intr(cpu_intr_o), .cpu_nmi(cpu_nmi_o),
    .lint0(lint0_o), .lint1(lint1_o)
  );

  // R1: reset returns to the direct route
  a_r1_reset_direct: assert property (@(posedge clk) disable iff (init)
    rst |=> (mode == ROUTE_DIRECT));

endmodule

// File: tb/tb_irq_mode_ctl.sv
module tb_irq_mode_ctl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst, init, io_wr, io_rd, pic_intr, nmi;
  logic [15:0] io_addr;
  logic [7:0]  io_wdata;
  logic [7:0]  rdata, rdata_w;
  logic        cpu_intr, cpu_nmi, lint0, lint1;
  logic        cpu_intr_w, cpu_nmi_w, lint0_w, lint1_w;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_mode_ctl dut (
    .clk(clk), .rst(rst), .init(init), .io_wr_i(io_wr), .io_rd_i(io_rd),
    .io_addr_i(io_addr), .io_wdata_i(io_wdata), .io_rdata_o(rdata),
    .pic_intr_i(pic_intr), .nmi_i(nmi), .cpu_intr_o(cpu_intr),
    .cpu_nmi_o(cpu_nmi), .lint0_o(lint0), .lint1_o(lint1));

  irq_mode_ctl #(.READABLE(1'b0)) dut_wo (
    .clk(clk), .rst(rst), .init(init), .io_wr_i(io_wr), .io_rd_i(io_rd),
    .io_addr_i(io_addr), .io_wdata_i(io_wdata), .io_rdata_o(rdata_w),
    .pic_intr_i(pic_intr), .nmi_i(nmi), .cpu_intr_o(cpu_intr_w),
    .cpu_nmi_o(cpu_nmi_w), .lint0_o(lint0_w), .lint1_o(lint1_w));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_wr = 1'b1; io_addr = a; io_wdata = d;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic io_read(input logic [15:0] a, output logic [7:0] v, output logic [7:0] vw);
    @(negedge clk);
    io_rd = 1'b1; io_addr = a;
    @(negedge clk);
    io_rd = 1'b0;
    v  = rdata;
    vw = rdata_w;
  endtask

  // Mode probed through the routing: lint0 carries a high request only in mode 1
  task automatic probe_mode(input string tag, input logic exp);
    pic_intr = 1'b1; nmi = 1'b0;
    #1;
    check(tag, lint0, exp);
    check(tag, lint0_w, exp);
    pic_intr = 1'b0;
  endtask

  task automatic route_sweep(input string tag, input logic m);
    for (int i = 0; i < 4; i++) begin
      pic_intr = i[0]; nmi = i[1];
      #1;
      check(tag, {cpu_intr, cpu_nmi, lint0, lint1},
            m ? {2'b00, i[0], i[1]} : {i[0], i[1], 2'b00});
    end
    pic_intr = 1'b0; nmi = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, vw;
    rst = 1'b1; init = 1'b0; io_wr = 1'b0; io_rd = 1'b0;
    io_addr = '0; io_wdata = '0; pic_intr = 1'b0; nmi = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1 reset state
    io_read(16'h0022, v, vw); check("R1 index after reset", v, 8'h00);
    route_sweep("R1 direct after reset", 1'b0);
    check("R11 idle rdata", rdata, 8'h00);

    // R3 index write and read
    io_write(16'h0022, 8'h70);
    io_read(16'h0022, v, vw); check("R3 index readback", v, 8'h70);
    @(negedge clk); check("R11 rdata back to zero", rdata, 8'h00);

    // R4/R6 full data-byte sweep with index 0x70
    for (int d = 0; d < 256; d++) begin
      io_write(16'h0023, 8'(d));
      probe_mode("R4 data sweep mode", d[0]);
      io_read(16'h0023, v, vw);
      check("R6 data readback", v, {7'b0, d[0]});
      check("R10 write-only read", vw, 8'h00);
    end

    // R7 index persisted through all data writes
    io_read(16'h0022, v, vw); check("R7 index persists", v, 8'h70);

    // R8/R9 routing in both modes
    io_write(16'h0023, 8'h00); route_sweep("R8 direct route", 1'b0);
    io_write(16'h0023, 8'h01); route_sweep("R9 lapic route", 1'b1);
    io_write(16'h0023, 8'hFE); route_sweep("R6 upper bits ignored", 1'b0);

    // R5 index sweep: only 0x70 lets the clearing write through
    for (int idx = 0; idx < 256; idx++) begin
      io_write(16'h0022, 8'h70);
      io_write(16'h0023, 8'h01);
      io_write(16'h0022, 8'(idx));
      io_write(16'h0023, 8'h00);
      probe_mode("R5 index sweep mode", (idx == 8'h70) ? 1'b0 : 1'b1);
      io_read(16'h0023, v, vw);
      check("R6 read with index", v, 8'h00);
    end

    // R12 aliased and foreign addresses
    io_write(16'h0022, 8'h70);
    io_write(16'h0023, 8'h01);
    io_write(16'h0122, 8'h00);
    io_write(16'h0123, 8'h00);
    io_write(16'h0021, 8'h00);
    probe_mode("R12 mode untouched", 1'b1);
    io_read(16'h0022, v, vw); check("R12 index untouched", v, 8'h70);
    io_read(16'h0123, v, vw); check("R11 foreign read zero", v, 8'h00);

    // R2 INIT with a simultaneous data write
    @(negedge clk);
    init = 1'b1; io_wr = 1'b1; io_addr = 16'h0023; io_wdata = 8'h01;
    @(negedge clk);
    init = 1'b0; io_wr = 1'b0;
    probe_mode("R2 init clears mode", 1'b0);
    io_read(16'h0022, v, vw); check("R2 init clears index", v, 8'h00);
    io_write(16'h0023, 8'h01);
    probe_mode("R2 index cleared blocks write", 1'b0);

    // R1 reset mid-operation
    io_write(16'h0022, 8'h70);
    io_write(16'h0023, 8'h01);
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    route_sweep("R1 reset restores direct", 1'b0);
    io_read(16'h0022, v, vw); check("R1 index cleared", v, 8'h00);
    check("R10 write-only index read", vw, 8'h00);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule